// File: doc/BRIEF.md
# I2C Master Address-Phase Controller

This block runs the opening of an I2C master transaction. The host writes a byte holding a 7-bit target address and a direction flag into a data register, then pulses a start request. The block forms a START condition and clocks the byte onto the bus with the most significant bit first. It releases SDA for the ninth clock and samples the acknowledge there. The result decides what happens next. An acknowledged address puts the block into master-transmit or master-receive mode, and the block then holds SCL low until the host asks for a STOP. An unacknowledged address makes the block issue a STOP by itself and raise a sticky bus-error flag.

Both bus lines are open-drain. The block only pulls a line low or lets it go, and it reads the wired SDA level back through an input pin. SCL timing comes from a divider of the system clock: each low half and each high half of a bus clock lasts `CLK_DIV` system clocks. Multi-master arbitration and clock stretching are not handled.

Top module: `i2c_addr_master`

## Requirements
- R1: A one-cycle `host_start` pulse starts a transaction only when the block is idle and `bus_err` is 0. `busy` is 1 in the next cycle. A start pulse during a transaction has no effect.
- R2: The first byte sent is the value last loaded through `host_data_we`: bits 7:1 carry the target address and bit 0 the direction (0 = write, 1 = read). Bits go out in order from bit 7 to bit 0, and each bit is stable on SDA while SCL is released.
- R3: The START hold, and each low half and each high half of every bus clock, lasts `CLK_DIV` system clocks. The pin outputs follow the internal phase sequence with one register of delay.
- R4: SDA changes only in a cycle where SCL was held low in the cycle before. There are two exceptions: the START edge (SDA pulled low while SCL is released) and the STOP edge (SDA released while SCL is released). When SCL falls, SDA keeps its previous level for one more cycle.
- R5: After reset, `scl_low`, `sda_low`, `busy`, `mode_tx`, `mode_rx` and `bus_err` are all 0 (both lines released).
- R6: During the high half of the ninth clock the block does not pull SDA low.
- R7: If SDA reads 0 at the end of the ninth clock and the direction bit is 0, `mode_tx` is 1 in the next cycle. SCL then stays held low until a stop request.
- R8: If SDA reads 0 at the end of the ninth clock and the direction bit is 1, `mode_rx` is 1 in the next cycle. SCL then stays held low until a stop request.
- R9: If SDA reads 1 at the end of the ninth clock, the block generates a STOP with no host action and sets `bus_err`.
- R10: `bus_err` stays 1 until a cycle with `host_err_clr` = 1 clears it. While it is 1, start pulses are ignored.
- R11: A `host_stop` pulse in transmit or receive mode produces a STOP. SDA is pulled low with SCL low, then SCL is released, then SDA is released. Afterwards `busy`, `mode_tx` and `mode_rx` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 8 | Address byte to load: address in 7:1, direction in 0 |
| host_data_we | input | 1 | Load `host_data` into the data register |
| host_start | input | 1 | Start request pulse |
| host_stop | input | 1 | Stop request pulse, used in transmit or receive mode |
| host_err_clr | input | 1 | Write 1 to clear `bus_err` |
| sda_in | input | 1 | Wired level of the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A transaction is in progress |
| mode_tx | output | 1 | Address acknowledged, master-transmit mode |
| mode_rx | output | 1 | Address acknowledged, master-receive mode |
| bus_err | output | 1 | Sticky flag: address not acknowledged |

## Verification
The assertions assume the following about the inputs:
- Host request pulses last one cycle.
- `host_start` and `host_stop` are never raised together.
- `CLK_DIV` is at least 2.
- Only the addressed target drives SDA, and only around the ninth clock, so nothing else moves the line during the address byte.

The bench keeps within these limits. It drives every request for exactly one cycle between clock edges. Its target model watches the bus pins, captures eight rising SCL edges after a START, and pulls SDA low (or leaves it released, for a not-acknowledge) only from the falling edge after the eighth bit until the next falling edge.

// File: rtl/i2c_am_pkg.sv
// Shared types for the I2C master address-phase controller.
// Assumes: one byte of address and direction per transaction.
package i2c_am_pkg;

    localparam int unsigned BYTE_W = 8;

    // Bus phases; each timed phase lasts one divider period
    typedef enum logic [3:0] {
        ST_IDLE,   // lines released, waiting for a start request
        ST_START,  // SDA low while SCL released
        ST_BLOW,   // SCL low half of an address bit
        ST_BHIGH,  // SCL high half of an address bit
        ST_ALOW,   // SCL low half of the acknowledge clock
        ST_AHIGH,  // SCL high half of the acknowledge clock
        ST_HOLD,   // mode chosen, SCL held low
        ST_PLOW,   // stop set-up: SDA low, SCL low
        ST_PHIGH   // stop set-up: SDA low, SCL released
    } am_state_e;

endpackage

// File: rtl/i2c_am_divider.sv
// Phase timer: counts system clocks while a timed phase runs and
// flags the last cycle of each phase. Assumes CLK_DIV >= 2 and that
// run_i only drops at a phase boundary or while idle.
module i2c_am_divider #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Last cycle of the current phase
    assign tick_o = run_i && (cnt_q == LAST);

    // Count within a phase, restart at each phase boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    // R3: inside a phase the count advances by one every clock
    assert_phase_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

    // R3: a phase boundary restarts the count
    assert_phase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_am_status.sv
// Sticky bus-error flag: set by an address not-acknowledge,
// cleared only by a host write of 1. A set and a clear in the
// same cycle leave the flag set.
module i2c_am_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_o
);

    // Hold the error until explicitly cleared
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (set_i)
            err_o <= 1'b1;
        else if (clr_i)
            err_o <= 1'b0;
    end

    // R9: a not-acknowledge raises the flag in the next cycle
    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> err_o);

    // R10: without a clear the flag stays set
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> err_o);

endmodule

// File: rtl/i2c_am_pins.sv
// Open-drain pin stage: registers the wanted SCL and SDA levels.
// SDA may follow its wanted level only when SCL was already held
// low, or when the phase forms START or STOP (allow_i).
// Assumes the sequencer holds each wanted level for a whole phase.
module i2c_am_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_want_i,
    input  logic sda_want_i,
    input  logic allow_i,
    output logic scl_low_o,
    output logic sda_low_o
);

    // Register pin drives, delaying SDA until SCL is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low_o <= 1'b0;
            sda_low_o <= 1'b0;
        end else begin
            scl_low_o <= scl_want_i;
            if (scl_low_o || allow_i)
                sda_low_o <= sda_want_i;
        end
    end

    // R4: an SDA change with SCL released comes only from START or STOP
    assert_sda_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low_o) && !$past(scl_low_o)) |-> $past(allow_i));

endmodule

// File: rtl/i2c_am_seq.sv
// Address-phase sequencer: START, eight address bits MSB first,
// acknowledge clock, then the transmit or receive mode, or an
// automatic STOP on not-acknowledge. Assumes one-cycle request
// pulses and no clock stretching by the target.
module i2c_am_seq
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              err_i,
    input  logic [BYTE_W-1:0] addr_byte_i,
    input  logic              sda_in_i,
    output logic              run_o,
    output logic              scl_want_o,
    output logic              sda_want_o,
    output logic              allow_o,
    output logic              busy_o,
    output logic              mode_tx_o,
    output logic              mode_rx_o,
    output logic              nack_o,
    output logic              ack_high_o
);

    localparam int unsigned BCW = $clog2(BYTE_W);
    localparam logic [BCW-1:0] TOP_BIT = BCW'(BYTE_W - 1);

    am_state_e         state_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BCW-1:0]    bitcnt_q;
    logic              dir_q;

    // Phase sequence and address shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            dir_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i && !err_i) begin
                    state_q  <= ST_START;
                    shreg_q  <= addr_byte_i;
                    bitcnt_q <= TOP_BIT;
                    dir_q    <= addr_byte_i[0];
                end
                ST_START: if (tick_i) state_q <= ST_BLOW;
                ST_BLOW:  if (tick_i) state_q <= ST_BHIGH;
                ST_BHIGH: if (tick_i) begin
                    if (bitcnt_q == '0) begin
                        state_q <= ST_ALOW;
                    end else begin
                        bitcnt_q <= bitcnt_q - BCW'(1);
                        shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                        state_q  <= ST_BLOW;
                    end
                end
                ST_ALOW:  if (tick_i) state_q <= ST_AHIGH;
                ST_AHIGH: if (tick_i) state_q <= sda_in_i ? ST_PLOW : ST_HOLD;
                ST_HOLD:  if (stop_i) state_q <= ST_PLOW;
                ST_PLOW:  if (tick_i) state_q <= ST_PHIGH;
                ST_PHIGH: if (tick_i) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Wanted line levels for each phase
    always_comb begin
        scl_want_o = 1'b0;
        sda_want_o = 1'b0;
        unique case (state_q)
            ST_START:          sda_want_o = 1'b1;
            ST_BLOW: begin
                scl_want_o = 1'b1;
                sda_want_o = ~shreg_q[BYTE_W-1];
            end
            ST_BHIGH:          sda_want_o = ~shreg_q[BYTE_W-1];
            ST_ALOW, ST_HOLD:  scl_want_o = 1'b1;
            ST_PLOW: begin
                scl_want_o = 1'b1;
                sda_want_o = 1'b1;
            end
            ST_PHIGH:          sda_want_o = 1'b1;
            default: begin
                scl_want_o = 1'b0;
                sda_want_o = 1'b0;
            end
        endcase
    end

    // Status and control outputs derived from the phase
    assign allow_o    = (state_q == ST_IDLE) || (state_q == ST_START);
    assign run_o      = (state_q != ST_IDLE) && (state_q != ST_HOLD);
    assign busy_o     = (state_q != ST_IDLE);
    assign mode_tx_o  = (state_q == ST_HOLD) && !dir_q;
    assign mode_rx_o  = (state_q == ST_HOLD) && dir_q;
    assign nack_o     = (state_q == ST_AHIGH) && tick_i && sda_in_i;
    assign ack_high_o = (state_q == ST_AHIGH);

    // R1: an accepted start request enters the START phase
    assert_start_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start_i && !err_i) |=> (state_q == ST_START) && busy_o);

    // R1: a start request during a transaction does not restart it
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLD) && start_i && !stop_i) |=> (state_q == ST_HOLD));

    // R7: acknowledge of a write address selects transmit mode
    assert_mode_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_AHIGH) && tick_i && !sda_in_i && !dir_q) |=> (mode_tx_o && !mode_rx_o));

    // R8: acknowledge of a read address selects receive mode
    assert_mode_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_AHIGH) && tick_i && !sda_in_i && dir_q) |=> (mode_rx_o && !mode_tx_o));

    // R9: a not-acknowledge goes straight into the stop sequence
    assert_nack_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |=> (state_q == ST_PLOW));

    // R10: a start request is refused while the error flag is set
    assert_start_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && err_i) |=> (state_q == ST_IDLE));

    // R11: a stop request in a mode begins the stop sequence
    assert_stop_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLD) && stop_i) |=> (state_q == ST_PLOW));

endmodule

// File: rtl/i2c_addr_master.sv
// Top of the I2C master address-phase controller. Holds the host
// data register and wires the phase timer, sequencer, pin stage
// and error flag. Assumes open-drain pads outside: a 1 on scl_low
// or sda_low enables the pull-down.
module i2c_addr_master
    import i2c_am_pkg::*;
#(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              host_data_we,
    input  logic              host_start,
    input  logic              host_stop,
    input  logic              host_err_clr,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              busy,
    output logic              mode_tx,
    output logic              mode_rx,
    output logic              bus_err
);

    logic [BYTE_W-1:0] data_q;
    logic run, tick, scl_want, sda_want, allow, nack, ack_high;

    // Host data register holding address and direction
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (host_data_we)
            data_q <= host_data;
    end

    i2c_am_divider #(.CLK_DIV(CLK_DIV)) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    i2c_am_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .start_i     (host_start),
        .stop_i      (host_stop),
        .err_i       (bus_err),
        .addr_byte_i (data_q),
        .sda_in_i    (sda_in),
        .run_o       (run),
        .scl_want_o  (scl_want),
        .sda_want_o  (sda_want),
        .allow_o     (allow),
        .busy_o      (busy),
        .mode_tx_o   (mode_tx),
        .mode_rx_o   (mode_rx),
        .nack_o      (nack),
        .ack_high_o  (ack_high)
    );

    i2c_am_pins u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_want_i (scl_want),
        .sda_want_i (sda_want),
        .allow_i    (allow),
        .scl_low_o  (scl_low),
        .sda_low_o  (sda_low)
    );

    i2c_am_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (nack),
        .clr_i (host_err_clr),
        .err_o (bus_err)
    );

    // R6: the high half of the ninth clock leaves SDA released
    assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_high |=> !sda_low);

    // R7: transmit and receive modes never coexist
    assert_mode_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_tx && mode_rx));

    // R11: no mode is reported while idle
    assert_idle_no_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mode_tx || mode_rx));

endmodule

// File: tb/test_i2c_addr_master.sv
module test_i2c_addr_master;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = '0;
    logic       host_data_we = 1'b0;
    logic       host_start = 1'b0;
    logic       host_stop = 1'b0;
    logic       host_err_clr = 1'b0;
    logic       scl_low, sda_low, busy, mode_tx, mode_rx, bus_err;
    logic       tgt_low = 1'b0;
    logic       sda_in;

    assign sda_in = ~(sda_low | tgt_low);

    always #10 clk = ~clk;

    i2c_addr_master #(.CLK_DIV(DIV)) i_i2c_addr_master (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_data_we(host_data_we),
        .host_start(host_start), .host_stop(host_stop), .host_err_clr(host_err_clr),
        .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low), .busy(busy),
        .mode_tx(mode_tx), .mode_rx(mode_rx), .bus_err(bus_err)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model: per-cycle entries {scl_low, sda_target, start/stop allowed}
    logic [2:0] q[$];
    logic [2:0] rest = 3'b001;
    logic       cmp_en = 1'b0;
    logic       prev_scl = 1'b0;
    logic       prev_sda = 1'b0;

    task automatic push(input logic [2:0] e, input int n);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    // Compare pins with the model every cycle (R3 SCL timing, R4 SDA rule)
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [2:0] e;
            logic exp_sda;
            e = (q.size() > 0) ? q.pop_front() : rest;
            exp_sda = (prev_scl || e[0]) ? e[1] : prev_sda;
            chk("R3 scl_low", scl_low, e[2]);
            chk("R4 sda_low", sda_low, exp_sda);
            prev_scl = e[2];
            prev_sda = exp_sda;
        end
    end

    // Target model on the bus pins
    logic       ack_en = 1'b1;
    logic [7:0] cap = '0;
    int         nbits = 9;
    logic       acking = 1'b0;
    logic       p_scl = 1'b1;
    logic       p_sda = 1'b1;

    always @(negedge clk) begin
        if (cmp_en) begin
            logic b_scl, b_sda;
            b_scl = ~scl_low;
            b_sda = sda_in;
            if (tgt_low && b_scl)
                chk("R6 sda released in ack", sda_low, 1'b0);
            if (p_scl && b_scl && p_sda && !b_sda) begin
                nbits = 0;
                cap = '0;
                acking = 1'b0;
            end else if (!p_scl && b_scl) begin
                if (nbits < 8) begin
                    cap = {cap[6:0], b_sda};
                    nbits++;
                end
            end else if (p_scl && !b_scl) begin
                if (acking) begin
                    tgt_low = 1'b0;
                    acking = 1'b0;
                    nbits = 9;
                end else if (nbits == 8) begin
                    tgt_low = ack_en;
                    acking = 1'b1;
                end
            end
            p_scl = b_scl;
            p_sda = sda_in;
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Address transaction: load, start, expected waveform
    task automatic txn(input logic [7:0] b, input logic a);
        @(negedge clk); #1;
        host_data = b; host_data_we = 1'b1; ack_en = a;
        @(negedge clk); #1;
        host_data_we = 1'b0; host_start = 1'b1;
        push(3'b001, 1);
        push(3'b011, DIV);
        for (int i = 7; i >= 0; i--) begin
            push({1'b1, ~b[i], 1'b0}, DIV);
            push({1'b0, ~b[i], 1'b0}, DIV);
        end
        push(3'b100, DIV);
        push(3'b000, DIV);
        if (a) begin
            rest = 3'b100;
        end else begin
            push(3'b110, DIV);
            push(3'b010, DIV);
            rest = 3'b001;
        end
        @(negedge clk);
        chk("R1 busy after start", busy, 1'b1);
        #1 host_start = 1'b0;
        drain();
    endtask

    task automatic stop_seq();
        @(negedge clk); #1;
        host_stop = 1'b1;
        push(3'b100, 1);
        push(3'b110, DIV);
        push(3'b010, DIV);
        rest = 3'b001;
        @(negedge clk); #1 host_stop = 1'b0;
        drain();
        chk("R11 busy after stop", busy, 1'b0);
        chk("R11 modes after stop", {mode_tx, mode_rx}, 2'b00);
    endtask

    task automatic pulse_start_ignored();
        @(negedge clk); #1 host_start = 1'b1;
        @(negedge clk); #1 host_start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1; cmp_en = 1'b1;
        @(negedge clk);
        chk("R5 reset scl_low", scl_low, 1'b0);
        chk("R5 reset sda_low", sda_low, 1'b0);
        chk("R5 reset busy", busy, 1'b0);
        chk("R5 reset modes", {mode_tx, mode_rx}, 2'b00);
        chk("R5 reset bus_err", bus_err, 1'b0);

        // Write to address 0x52, acknowledged
        txn(8'hA4, 1'b1);
        chk("R2 captured byte", cap, 8'hA4);
        chk("R7 mode_tx", mode_tx, 1'b1);
        chk("R7 mode_rx", mode_rx, 1'b0);
        chk("R7 no error", bus_err, 1'b0);

        // Start while in a mode is ignored
        pulse_start_ignored();
        chk("R1 start ignored busy", busy, 1'b1);
        chk("R1 start ignored mode", mode_tx, 1'b1);
        stop_seq();

        // Read from address 0x1D, acknowledged
        txn(8'h3B, 1'b1);
        chk("R2 captured byte", cap, 8'h3B);
        chk("R8 mode_rx", mode_rx, 1'b1);
        chk("R8 mode_tx", mode_tx, 1'b0);
        stop_seq();

        // Not acknowledged: automatic stop and error
        txn(8'h80, 1'b0);
        chk("R2 captured byte", cap, 8'h80);
        chk("R9 bus_err set", bus_err, 1'b1);
        chk("R9 idle after auto stop", busy, 1'b0);
        chk("R9 no mode", {mode_tx, mode_rx}, 2'b00);

        // Start refused while error pending
        pulse_start_ignored();
        chk("R10 start refused busy", busy, 1'b0);
        chk("R10 error sticky", bus_err, 1'b1);

        @(negedge clk); #1 host_err_clr = 1'b1;
        @(negedge clk); #1 host_err_clr = 1'b0;
        @(negedge clk);
        chk("R10 error cleared", bus_err, 1'b0);

        // All-ones read after clearing
        txn(8'hFF, 1'b1);
        chk("R2 captured byte", cap, 8'hFF);
        chk("R8 mode_rx", mode_rx, 1'b1);
        stop_seq();

        // Write to address 0, acknowledged (all-zero byte)
        txn(8'h00, 1'b1);
        chk("R2 captured byte", cap, 8'h00);
        chk("R7 mode_tx", mode_tx, 1'b1);
        stop_seq();

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule